// File: doc/BRIEF.md
# Tiled Vector Addition Accelerator

This block adds two arrays of signed 32-bit integers element by element and writes the result array back to memory. Software sets three base addresses (input A, input B, result C) and an element count through a small register port. It then sets the start bit and polls the control word until the done bit is set.

The work is cut into tiles of at most `TILE` elements, 256 by default. For each tile the block fetches the A slice and then the B slice as two bursts on one shared read port, and stores them in two local banks. It then streams the sums out as one burst on a separate write port. The last tile is shortened to the elements that remain. Byte addresses step by 4 per element, so tile k starts at each base plus k·1024 bytes.

Top module: `vadd_accel`

## Requirements
- R1: Each result word equals the two's-complement sum, modulo 2^32, of the A and B words at the same index.
- R2: Every burst on either port has a length (the `*_len` field, counted in beats) from 1 to `TILE`. The length is `TILE` except in the last tile, where it is the element count minus the tile's first index.
- R3: A tile's bursts start at the A, B and C bases plus 4·(first index of the tile). With the default tile this is the tile number times 1024 bytes.
- R4: Within a tile the read port carries the A burst and then the B burst, and both complete before the write request for that tile is raised. Read and write requests are never raised in the same cycle.
- R5: Results leave only through the write port, as one write burst per tile whose beats go to consecutive word addresses starting at the burst address.
- R6: The control word is at offset 0x00. Bit 0 is start and reads back as 0. Bit 1 is done: it is set when the job ends and stays set until the next accepted start clears it. Bit 2 is idle. After reset the control word reads 0x4.
- R7: A start with an element count of zero sets done on the same clock edge, leaves the block idle and issues no memory request.
- R8: While a job runs, writes to any register are ignored, including a second start. A readback after the write returns the old value.
- R9: The block accepts read data on every cycle in which `rd_data_valid` is high, with no ready signal. It presents write data in every cycle of a write burst, so a write burst with `wr_data_ready` held high takes exactly its length in cycles.
- R10: A request or a write data beat that is not accepted is held with unchanged address, length and data until it is accepted.
- R11: The A, B and C bases and the element count are at offsets 0x10, 0x18, 0x20 and 0x28 and read back the value last written while idle. All of them read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 6 | Register write byte offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 6 | Register read byte offset |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| rd_req_valid | output | 1 | Read burst request valid |
| rd_req_ready | input | 1 | Read burst request accepted |
| rd_req_addr | output | 32 | Read burst byte address |
| rd_req_len | output | 9 | Read burst length in beats |
| rd_data_valid | input | 1 | Read data beat valid, always taken |
| rd_data | input | 32 | Read data beat |
| wr_req_valid | output | 1 | Write burst request valid |
| wr_req_ready | input | 1 | Write burst request accepted |
| wr_req_addr | output | 32 | Write burst byte address |
| wr_req_len | output | 9 | Write burst length in beats |
| wr_data_valid | output | 1 | Write data beat valid |
| wr_data_ready | input | 1 | Write data beat accepted |
| wr_data | output | 32 | Write data beat (sum) |

## Verification
Two events can fall on the same edge here.

The first is a new start and a done bit that is still set. The bench starts a second job while done is still high from the previous one. It then reads the control word on the next cycle and expects done=0 and idle=0. A zero-count start made before any other job must instead raise done at once with no memory traffic.

The second is a register write and a running job. The bench writes a new count, a new A base and a second start partway through a job. It then expects the old readback values and a result stream that is unchanged.

A scoreboard holds the predicted bursts and sums. It is checked under stalls on requests and data, and in a mode without stalls that measures burst continuity.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RDA_REQ,
      ST_RDA_DAT,
      ST_RDB_REQ,
      ST_RDB_DAT,
      ST_WR_REQ,
      ST_WR_DAT
   } vadd_state_e;

   localparam int          REG_AW    = 6;
   localparam logic [5:0]  OFF_CTRL  = 6'h00;
   localparam logic [5:0]  OFF_ABASE = 6'h10;
   localparam logic [5:0]  OFF_BBASE = 6'h18;
   localparam logic [5:0]  OFF_CBASE = 6'h20;
   localparam logic [5:0]  OFF_COUNT = 6'h28;
   localparam int          CTRL_START_BIT = 0;
endpackage

// File: rtl/vadd_cfg_regs.sv
module vadd_cfg_regs
   import vadd_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    wr_addr,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [REG_AW-1:0]    rd_addr,
   output logic [REG_W-1:0]     rd_data,
   input  logic                 busy,
   input  logic                 done,
   output logic                 start_pulse,
   output logic [ADDR_W-1:0]    a_base,
   output logic [ADDR_W-1:0]    b_base,
   output logic [ADDR_W-1:0]    c_base,
   output logic [CNT_W-1:0]     count
);
   initial begin
      if (ADDR_W > REG_W || CNT_W > REG_W)
         $error("vadd_cfg_regs: fields wider than the register bus");
   end

   logic wr_ok;
   assign wr_ok       = wr_en && !busy;
   assign start_pulse = wr_ok && (wr_addr == OFF_CTRL) && wr_data[CTRL_START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_base <= '0;
         b_base <= '0;
         c_base <= '0;
         count  <= '0;
      end else if (wr_ok) begin
         case (wr_addr)
            OFF_ABASE: a_base <= wr_data[ADDR_W-1:0];
            OFF_BBASE: b_base <= wr_data[ADDR_W-1:0];
            OFF_CBASE: c_base <= wr_data[ADDR_W-1:0];
            OFF_COUNT: count  <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         OFF_CTRL:  rd_data = REG_W'({!busy, done, 1'b0});
         OFF_ABASE: rd_data = REG_W'(a_base);
         OFF_BBASE: rd_data = REG_W'(b_base);
         OFF_CBASE: rd_data = REG_W'(c_base);
         OFF_COUNT: rd_data = REG_W'(count);
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/vadd_tile_buf.sv
module vadd_tile_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              sel,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] sum
);
   localparam int NBANK = 2;

   logic [DATA_W-1:0] bank_rd [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic [DATA_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (sel == 1'(g)))
            store[widx] <= wdata;
      end
      assign bank_rd[g] = store[ridx];
   end

   assign sum = bank_rd[0] + bank_rd[1];
endmodule

// File: rtl/vadd_tile_seq.sv
module vadd_tile_seq
   import vadd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int TILE   = 256,
   localparam int LEN_W = $clog2(TILE + 1),
   localparam int IDX_W = $clog2(TILE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] a_base,
   input  logic [ADDR_W-1:0] b_base,
   input  logic [ADDR_W-1:0] c_base,
   input  logic [CNT_W-1:0]  count,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic [LEN_W-1:0]  rd_req_len,
   input  logic              rd_data_valid,
   output logic              wr_req_valid,
   input  logic              wr_req_ready,
   output logic [ADDR_W-1:0] wr_req_addr,
   output logic [LEN_W-1:0]  wr_req_len,
   output logic              wr_data_valid,
   input  logic              wr_data_ready,
   output logic              buf_we,
   output logic              buf_sel,
   output logic [IDX_W-1:0]  buf_idx,
   output logic              busy,
   output logic              done
);
   localparam int BSH = $clog2(DATA_W / 8);

   vadd_state_e       st_q;
   logic [CNT_W-1:0]  tstart_q;
   logic [CNT_W-1:0]  remain;
   logic [LEN_W-1:0]  beat_q;
   logic [LEN_W-1:0]  tlen;
   logic [ADDR_W-1:0] offs;
   logic              last_beat;
   logic              tail_tile;
   logic              done_q;

   assign remain    = count - tstart_q;
   assign tlen      = (remain > CNT_W'(TILE)) ? LEN_W'(TILE) : LEN_W'(remain);
   assign last_beat = (beat_q == tlen - LEN_W'(1));
   assign tail_tile = (tstart_q + CNT_W'(tlen)) >= count;
   assign offs      = ADDR_W'(tstart_q) << BSH;

   assign rd_req_valid  = (st_q == ST_RDA_REQ) || (st_q == ST_RDB_REQ);
   assign rd_req_addr   = ((st_q == ST_RDB_REQ) ? b_base : a_base) + offs;
   assign rd_req_len    = tlen;
   assign wr_req_valid  = (st_q == ST_WR_REQ);
   assign wr_req_addr   = c_base + offs;
   assign wr_req_len    = tlen;
   assign wr_data_valid = (st_q == ST_WR_DAT);

   assign buf_we  = rd_data_valid && ((st_q == ST_RDA_DAT) || (st_q == ST_RDB_DAT));
   assign buf_sel = (st_q == ST_RDB_DAT);
   assign buf_idx = beat_q[IDX_W-1:0];
   assign busy    = (st_q != ST_IDLE);
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         tstart_q <= '0;
         beat_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               tstart_q <= '0;
               if (count == '0) begin
                  done_q <= 1'b1;
               end else begin
                  done_q <= 1'b0;
                  st_q   <= ST_RDA_REQ;
               end
            end
            ST_RDA_REQ: if (rd_req_ready) begin
               beat_q <= '0;
               st_q   <= ST_RDA_DAT;
            end
            ST_RDA_DAT: if (rd_data_valid) begin
               beat_q <= beat_q + LEN_W'(1);
               if (last_beat) st_q <= ST_RDB_REQ;
            end
            ST_RDB_REQ: if (rd_req_ready) begin
               beat_q <= '0;
               st_q   <= ST_RDB_DAT;
            end
            ST_RDB_DAT: if (rd_data_valid) begin
               beat_q <= beat_q + LEN_W'(1);
               if (last_beat) st_q <= ST_WR_REQ;
            end
            ST_WR_REQ: if (wr_req_ready) begin
               beat_q <= '0;
               st_q   <= ST_WR_DAT;
            end
            ST_WR_DAT: if (wr_data_ready) begin
               beat_q <= beat_q + LEN_W'(1);
               if (last_beat) begin
                  if (tail_tile) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     tstart_q <= tstart_q + CNT_W'(tlen);
                     st_q     <= ST_RDA_REQ;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vadd_accel.sv
module vadd_accel
   import vadd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int REG_W  = 32,
   parameter int TILE   = 256,
   localparam int LEN_W = $clog2(TILE + 1),
   localparam int IDX_W = $clog2(TILE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [5:0]        cfg_wr_addr,
   input  logic [REG_W-1:0]  cfg_wr_data,
   input  logic [5:0]        cfg_rd_addr,
   output logic [REG_W-1:0]  cfg_rd_data,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic [LEN_W-1:0]  rd_req_len,
   input  logic              rd_data_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_req_valid,
   input  logic              wr_req_ready,
   output logic [ADDR_W-1:0] wr_req_addr,
   output logic [LEN_W-1:0]  wr_req_len,
   output logic              wr_data_valid,
   input  logic              wr_data_ready,
   output logic [DATA_W-1:0] wr_data
);
   initial begin
      if (TILE < 2 || TILE > 256)
         $error("vadd_accel: TILE must lie in 2..256");
      if (DATA_W != 32)
         $error("vadd_accel: only 32-bit elements are supported");
   end

   logic              busy;
   logic              done;
   logic              start_pulse;
   logic [ADDR_W-1:0] a_base, b_base, c_base;
   logic [CNT_W-1:0]  cnt_q;
   logic              buf_we, buf_sel;
   logic [IDX_W-1:0]  buf_idx;

   vadd_cfg_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
      .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
      .busy(busy), .done(done), .start_pulse(start_pulse),
      .a_base(a_base), .b_base(b_base), .c_base(c_base), .count(cnt_q)
   );

   vadd_tile_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TILE(TILE)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start_pulse),
      .a_base(a_base), .b_base(b_base), .c_base(c_base), .count(cnt_q),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
      .rd_data_valid(rd_data_valid),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
      .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len),
      .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
      .buf_we(buf_we), .buf_sel(buf_sel), .buf_idx(buf_idx),
      .busy(busy), .done(done)
   );

   vadd_tile_buf #(.DATA_W(DATA_W), .DEPTH(TILE)) buf_i (
      .clk(clk), .we(buf_we), .sel(buf_sel), .widx(buf_idx),
      .wdata(rd_data), .ridx(buf_idx), .sum(wr_data)
   );
endmodule

// File: rtl/vadd_accel_chk.sv
module vadd_accel_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int TILE   = 256,
   parameter int LEN_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_valid,
   input logic              rd_req_ready,
   input logic [ADDR_W-1:0] rd_req_addr,
   input logic [LEN_W-1:0]  rd_req_len,
   input logic              wr_req_valid,
   input logic              wr_req_ready,
   input logic [ADDR_W-1:0] wr_req_addr,
   input logic [LEN_W-1:0]  wr_req_len,
   input logic              wr_data_valid,
   input logic              wr_data_ready,
   input logic [DATA_W-1:0] wr_data,
   input logic              cfg_wr_en,
   input logic              busy,
   input logic              done,
   input logic              start_pulse,
   input logic [CNT_W-1:0]  cnt_q
);
   p_rd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rd_req_len != '0) && (rd_req_len <= LEN_W'(TILE)));
   p_wr_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_valid |-> (wr_req_len != '0) && (wr_req_len <= LEN_W'(TILE)));
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_valid || wr_data_valid) |-> !rd_req_valid);
   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_pulse) |=> done);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && cnt_q == '0) |=> (done && !busy && !rd_req_valid));
   p_cfg_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr_en) |=> $stable(cnt_q));
   p_rdreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=>
         (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)));
   p_wrreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_valid && !wr_req_ready) |=>
         (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_len)));
   p_wrdat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_valid && !wr_data_ready) |=> (wr_data_valid && $stable(wr_data)));
endmodule

bind vadd_accel vadd_accel_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TILE(TILE), .LEN_W(LEN_W)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
   .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
   .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
   .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len),
   .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
   .wr_data(wr_data), .cfg_wr_en(cfg_wr_en),
   .busy(busy), .done(done), .start_pulse(start_pulse), .cnt_q(cnt_q)
);

// File: tb/vadd_accel_tb_top.sv
module vadd_accel_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TILE  = 256;
   localparam int LEN_W = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en;
   logic [5:0]  cfg_wr_addr, cfg_rd_addr;
   logic [31:0] cfg_wr_data, cfg_rd_data;
   logic        rd_req_valid, rd_req_ready;
   logic [31:0] rd_req_addr;
   logic [LEN_W-1:0] rd_req_len;
   logic        rd_data_valid;
   logic [31:0] rd_data;
   logic        wr_req_valid, wr_req_ready;
   logic [31:0] wr_req_addr;
   logic [LEN_W-1:0] wr_req_len;
   logic        wr_data_valid, wr_data_ready;
   logic [31:0] wr_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   vadd_accel #(.TILE(TILE)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
      .rd_data_valid(rd_data_valid), .rd_data(rd_data),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
      .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len),
      .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
      .wr_data(wr_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit ended   = 0;
   bit full_speed = 0;
   int stalls  = 0;

   logic [31:0] mem [int unsigned];
   logic [31:0] exp_rd_addr[$];
   int          exp_rd_len[$];
   logic [31:0] exp_wr_addr[$];
   int          exp_wr_len[$];
   logic [31:0] exp_d_addr[$];
   logic [31:0] exp_d_val[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_get(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'hDEAD_BEEF;
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // memory model and scoreboard monitor
   initial begin : mem_model
      int rd_left = 0, rd_gap = 0, wr_left = 0, cyc = 0;
      logic [31:0] rd_ptr = '0, wr_ptr = '0;
      rd_req_ready  = 1'b1;
      rd_data_valid = 1'b0;
      rd_data       = '0;
      wr_req_ready  = 1'b0;
      wr_data_ready = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         // read data beat for the coming edge
         if (rd_left > 0 && rd_gap == 0) begin
            rd_data_valid = 1'b1;
            rd_data       = mem_get(rd_ptr);
            rd_ptr        = rd_ptr + 32'd4;
            rd_left--;
            if (!full_speed && (cyc % 7 == 0)) rd_gap = 1;
         end else begin
            rd_data_valid = 1'b0;
            if (rd_gap > 0) rd_gap--;
         end
         // read request (ready held high)
         if (rst_n && rd_req_valid) begin
            if (exp_rd_addr.size() == 0) begin
               check(0, "R7", "unexpected read request", rd_req_addr, 0);
            end else begin
               logic [31:0] ea;
               int el;
               ea = exp_rd_addr.pop_front();
               el = exp_rd_len.pop_front();
               check(rd_req_addr == ea, "R3", "read burst address", rd_req_addr, ea);
               check(int'(rd_req_len) == el, "R2", "read burst length", rd_req_len, el);
               check(rd_left == 0, "R4", "read request while burst open", rd_left, 0);
            end
            rd_left = int'(rd_req_len);
            rd_ptr  = rd_req_addr;
            rd_gap  = full_speed ? 0 : 2;
         end
         // write data beat for the coming edge
         wr_data_ready = full_speed ? 1'b1 : (cyc % 4 != 1);
         if (full_speed && wr_left > 0 && !wr_data_valid) stalls++;
         if (rst_n && wr_data_valid && wr_data_ready) begin
            if (exp_d_val.size() == 0 || wr_left == 0) begin
               check(0, "R5", "write beat outside a burst", wr_data, 0);
            end else begin
               logic [31:0] ea, ev;
               ea = exp_d_addr.pop_front();
               ev = exp_d_val.pop_front();
               check(wr_ptr == ea, "R5", "write beat address", wr_ptr, ea);
               check(wr_data == ev, "R1", "sum value", wr_data, ev);
            end
            wr_ptr = wr_ptr + 32'd4;
            if (wr_left > 0) wr_left--;
         end
         // write request
         wr_req_ready = full_speed ? 1'b1 : (cyc % 3 != 0);
         if (rst_n && wr_req_valid && wr_req_ready) begin
            if (exp_wr_addr.size() == 0) begin
               check(0, "R7", "unexpected write request", wr_req_addr, 0);
            end else begin
               logic [31:0] ea;
               int el;
               ea = exp_wr_addr.pop_front();
               el = exp_wr_len.pop_front();
               check(wr_req_addr == ea, "R3", "write burst address", wr_req_addr, ea);
               check(int'(wr_req_len) == el, "R2", "write burst length", wr_req_len, el);
               check(exp_rd_addr.size() % 2 == 0 && rd_left == 0, "R4",
                     "write request before both reads", rd_left, 0);
            end
            wr_ptr  = wr_req_addr;
            wr_left = int'(wr_req_len);
         end
      end
   end

   task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic cfg_rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_rd_addr = a;
      #1 d = cfg_rd_data;
   endtask

   task automatic wait_done(input string req);
      logic [31:0] v;
      for (int i = 0; i < 40000; i++) begin
         cfg_rd(6'h00, v);
         if (v[1]) break;
      end
      check(v[2:1] == 2'b11, req, "control after job (done, idle)", v, 32'h6);
   endtask

   // driver: fills memory, pushes expectations, programs and starts
   task automatic run_job(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input int n, input int seed,
                          input bit disturb);
      logic [31:0] v;
      for (int i = 0; i < n; i++) begin
         logic [31:0] av, bv;
         av = 32'h7FFF_FF00 + 32'(i * seed);
         bv = 32'h0000_0100 - 32'(i * 7) ^ 32'(seed << 20);
         mem[a + 32'(4*i)] = av;
         mem[b + 32'(4*i)] = bv;
      end
      for (int ts = 0; ts < n; ts += TILE) begin
         int len;
         len = (n - ts > TILE) ? TILE : n - ts;
         exp_rd_addr.push_back(a + 32'(4*ts)); exp_rd_len.push_back(len);
         exp_rd_addr.push_back(b + 32'(4*ts)); exp_rd_len.push_back(len);
         exp_wr_addr.push_back(c + 32'(4*ts)); exp_wr_len.push_back(len);
         for (int j = 0; j < len; j++) begin
            exp_d_addr.push_back(c + 32'(4*(ts+j)));
            exp_d_val.push_back(mem[a + 32'(4*(ts+j))] + mem[b + 32'(4*(ts+j))]);
         end
      end
      cfg_wr(6'h10, a);
      cfg_wr(6'h18, b);
      cfg_wr(6'h20, c);
      cfg_wr(6'h28, 32'(n));
      cfg_wr(6'h00, 32'h1);
      // start with done previously set: done must clear on the same edge
      cfg_rd(6'h00, v);
      check(v[2:0] == 3'b000, "R6", "control while running", v, 0);
      if (disturb) begin
         repeat (30) @(negedge clk);
         cfg_wr(6'h28, 32'd3);
         cfg_wr(6'h10, 32'h0);
         cfg_wr(6'h00, 32'h1);
         cfg_rd(6'h28, v);
         check(v == 32'(n), "R8", "count after busy write", v, n);
         cfg_rd(6'h10, v);
         check(v == a, "R8", "A base after busy write", v, a);
      end
      wait_done("R6");
      repeat (3) @(negedge clk);
      check(exp_rd_addr.size() == 0, "R4", "read bursts left over", exp_rd_addr.size(), 0);
      check(exp_wr_addr.size() == 0, "R5", "write bursts left over", exp_wr_addr.size(), 0);
      check(exp_d_val.size() == 0, "R1", "sums left over", exp_d_val.size(), 0);
      cfg_rd(6'h00, v);
      check(v[1] == 1'b1, "R6", "done sticky", v, 32'h6);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin : main
      logic [31:0] v;
      cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0; cfg_rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      cfg_rd(6'h00, v);
      check(v == 32'h4, "R6", "control after reset", v, 32'h4);
      cfg_rd(6'h28, v);
      check(v == 32'h0, "R11", "count after reset", v, 0);
      check(!rd_req_valid && !wr_req_valid && !wr_data_valid, "R4",
            "no requests after reset", {rd_req_valid, wr_req_valid, wr_data_valid}, 0);
      // zero count, done rises from 0 with no traffic
      cfg_wr(6'h00, 32'h1);
      cfg_rd(6'h00, v);
      check(v == 32'h6, "R7", "control after zero-count start", v, 32'h6);
      repeat (20) @(negedge clk);
      // register readback
      cfg_wr(6'h10, 32'h0000_1000);
      cfg_wr(6'h18, 32'h0002_0000);
      cfg_wr(6'h20, 32'h0004_0000);
      cfg_wr(6'h28, 32'd77);
      cfg_rd(6'h10, v); check(v == 32'h0000_1000, "R11", "A base readback", v, 32'h1000);
      cfg_rd(6'h18, v); check(v == 32'h0002_0000, "R11", "B base readback", v, 32'h20000);
      cfg_rd(6'h20, v); check(v == 32'h0004_0000, "R11", "C base readback", v, 32'h40000);
      cfg_rd(6'h28, v); check(v == 32'd77, "R11", "count readback", v, 77);
      // multi-tile job with a short last tile, under stalls
      run_job(32'h0000_1000, 32'h0002_0000, 32'h0004_0000, 600, 3, 1'b0);
      // tiny job with overflowing sums
      run_job(32'h0001_0000, 32'h0003_0000, 32'h0005_0000, 5, 11, 1'b0);
      // exactly one full tile, with writes while busy
      run_job(32'h0000_8000, 32'h0002_8000, 32'h0004_8000, 256, 5, 1'b1);
      // no stalls: bursts must be continuous
      full_speed = 1;
      stalls = 0;
      run_job(32'h0006_0000, 32'h0007_0000, 32'h0008_0000, 300, 9, 1'b0);
      check(stalls == 0, "R9", "write burst gaps at full speed", stalls, 0);
      full_speed = 0;
      finish_run();
   end
endmodule